// File: doc/BRIEF.md
# PCI Configuration Space Target

This block is the target-side front end of a PCI function's configuration header. During an address phase it looks at the bus command, the address and the device-select strobe (`ap_idsel`). If the cycle is a configuration read or write meant for this function, it records the register number. The following data phase then either returns a doubleword from the header or merges a byte-enabled write into it. The header holds identification, command/status, class code, cache/latency, base address, subsystem and interrupt fields.

The same address-phase logic also qualifies memory reads and writes against the implemented base address windows. It claims such a cycle only when memory-space decoding has been enabled in the command register. The bus protocol is reduced to one-cycle strobes: `ap_valid` marks an address phase and `dp_valid` marks a data phase. The data phase of a claimed configuration cycle may arrive in the same cycle as the next address phase.

Top module: `pci_cfg_target`

## Requirements
- R1: A configuration cycle is claimed only when address bits [1:0] are 00 (Type 0). Any other value is ignored: `cfg_hit` stays low, a read returns no `rd_valid`, and a write changes nothing.
- R2: A configuration cycle is claimed only when `ap_idsel` is high and address bits [10:8] (function number) are 0. Any other function number is not claimed, so the host sees a master abort.
- R3: Address bits [7:2] give the register number. Numbers 0 to 15 are implemented. A claimed read of 16 to 63 returns all zeros, and a claimed write there changes no register, including the register whose low four index bits match.
- R4: Command 4'b1010 is a configuration read and 4'b1011 a configuration write. Command 4'b0110 is a memory read and 4'b0111 a memory write. Every other command is ignored, and `cfg_hit` and `mem_hit` are never high together.
- R5: Each write byte enable acts independently. `dp_be[k]` high allows bits [8k+7:8k] of the addressed register to change, and a low enable leaves that byte as it was.
- R6: These fields ignore writes: register 0 {device ID [31:16], vendor ID [15:0]}; register 2 {base class [31:24], sub-class [23:16], programming interface [15:8], revision [7:0]}; the status half of register 1; the upper half of register 3; the upper 24 bits of register 15; and registers 10, 12, 13 and 14. In register 1 only command bits 0, 1, 2, 6, 8 and 10 can be written. In register 3 bits [15:0] are writable, and in register 15 bits [7:0]. Register 11 is writable in full.
- R7: Registers 4 to 4+NUM_BARS-1 are 32-bit memory base address registers. Their low BAR_SIZE_LOG2 bits always read 0, so writing all ones reads back as the negated window size. Base address registers that are not implemented read zero.
- R8: Command register bit 1 is the memory-space enable and drives `mem_space_en`. A memory command is claimed (`mem_hit`) only while this bit is 1 and address bits [31:BAR_SIZE_LOG2] equal those of an implemented base address register.
- R9: A synchronous reset sets every writable field to its default: command 0, base addresses 0, cache/latency 0, interrupt line 0. Register 11 keeps its contents through reset. Right after reset, `cfg_hit`, `mem_hit`, `rd_valid` and `mem_space_en` are 0.
- R10: `cfg_hit` and `mem_hit` rise in the cycle after the address phase. `rd_valid` and `rd_data` appear in the cycle after the data phase. A write takes effect in time for the next read.
- R11: When a data phase and a new address phase fall in the same cycle, the address phase is qualified with the command register as it stood before that data phase's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ap_valid | input | 1 | Address phase strobe |
| ap_addr | input | 32 | Address sampled in the address phase |
| ap_cmd | input | 4 | Bus command sampled in the address phase |
| ap_idsel | input | 1 | Configuration device select |
| dp_valid | input | 1 | Data phase strobe |
| dp_wdata | input | 32 | Write data |
| dp_be | input | 4 | Active-high byte enables |
| cfg_hit | output | 1 | Configuration cycle claimed |
| mem_hit | output | 1 | Memory cycle claimed |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| mem_space_en | output | 1 | Memory-space decode enable |

## Verification
The data phase of a configuration write and the address phase of a memory cycle can share a cycle. The bench provokes this with a write that clears the memory-space enable while a memory read to a mapped address is presented in the same cycle. It expects `mem_hit` for that overlapping cycle, because the old enable applies, and no `mem_hit` for an identical memory cycle one cycle later. Configuration address phases that overlap a data phase are also judged: the pending write must still land on the earlier register.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

  localparam int NUM_REGS   = 16;
  localparam int IDX_W      = $clog2(NUM_REGS);
  localparam int REGNUM_W   = 6;
  localparam int BAR_FIRST  = 4;
  localparam int BAR_MAX    = 6;
  localparam int KEEP_IDX   = 11;
  localparam int CMD_IDX    = 1;
  localparam int MEM_EN_BIT = 1;

  typedef enum logic [3:0] {
    BUS_MEM_RD = 4'h6,
    BUS_MEM_WR = 4'h7,
    BUS_CFG_RD = 4'hA,
    BUS_CFG_WR = 4'hB
  } bus_cmd_e;

  function automatic logic [31:0] be_expand(logic [3:0] be);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{be[k]}};
    return m;
  endfunction

  // Writable bits of each header doubleword.
  function automatic logic [31:0] reg_wmask(int idx, int nbars, int lg2);
    logic [31:0] m;
    m = 32'h0;
    if (idx == CMD_IDX)                                      m = 32'h0000_0547;
    else if (idx == 3)                                       m = 32'h0000_FFFF;
    else if (idx == KEEP_IDX)                                m = 32'hFFFF_FFFF;
    else if (idx == 15)                                      m = 32'h0000_00FF;
    else if (idx >= BAR_FIRST && idx < BAR_FIRST + nbars)    m = ~((32'h1 << lg2) - 32'h1);
    return m;
  endfunction

endpackage

// File: rtl/cfgsp_decode.sv
module cfgsp_decode
  import cfgsp_pkg::*;
#(
  parameter int NUM_BARS      = 2,
  parameter int BAR_SIZE_LOG2 = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ap_valid,
  input  logic [31:0]           ap_addr,
  input  logic [3:0]            ap_cmd,
  input  logic                  ap_idsel,
  input  logic                  dp_valid,
  input  logic                  mem_en,
  input  logic [NUM_BARS*32-1:0] bar_bases,
  output logic                  cfg_hit,
  output logic                  mem_hit,
  output logic                  pend,
  output logic                  pend_wr,
  output logic [IDX_W-1:0]      pend_idx,
  output logic                  pend_inrange
);

  localparam int BASE_W = 32 - BAR_SIZE_LOG2;

  logic                  is_cfg, is_mem, cfg_ok, mem_ok;
  logic [1:0]            cyc_type;
  logic [2:0]            func_num;
  logic [REGNUM_W-1:0]   reg_num;
  logic [NUM_BARS-1:0]   bar_match;

  for (genvar b = 0; b < NUM_BARS; b++) begin : g_match
    assign bar_match[b] =
      (ap_addr[31:BAR_SIZE_LOG2] == bar_bases[b*32 + BAR_SIZE_LOG2 +: BASE_W]);
  end

  always_comb begin
    cyc_type = ap_addr[1:0];
    func_num = ap_addr[10:8];
    reg_num  = ap_addr[7:2];
    is_cfg   = (ap_cmd == BUS_CFG_RD) || (ap_cmd == BUS_CFG_WR);
    is_mem   = (ap_cmd == BUS_MEM_RD) || (ap_cmd == BUS_MEM_WR);
    cfg_ok   = ap_valid && ap_idsel && is_cfg && (cyc_type == 2'b00) && (func_num == 3'd0);
    mem_ok   = ap_valid && is_mem && mem_en && (|bar_match);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_hit      <= 1'b0;
      mem_hit      <= 1'b0;
      pend         <= 1'b0;
      pend_wr      <= 1'b0;
      pend_idx     <= '0;
      pend_inrange <= 1'b0;
    end else begin
      cfg_hit <= cfg_ok;
      mem_hit <= mem_ok;
      if (cfg_ok) begin
        pend         <= 1'b1;
        pend_wr      <= (ap_cmd == BUS_CFG_WR);
        pend_idx     <= reg_num[IDX_W-1:0];
        pend_inrange <= (reg_num[REGNUM_W-1:IDX_W] == '0);
      end else if (dp_valid) begin
        pend <= 1'b0;
      end
    end
  end

  AST_TYPE1_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (ap_valid && ap_addr[1:0] != 2'b00) |=> !cfg_hit); // R1
  AST_FUNC_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (ap_valid && (ap_addr[10:8] != 3'd0 || !ap_idsel)) |=> !cfg_hit); // R2
  AST_OTHER_CMD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (ap_valid && ap_cmd != BUS_CFG_RD && ap_cmd != BUS_CFG_WR &&
     ap_cmd != BUS_MEM_RD && ap_cmd != BUS_MEM_WR) |=> (!cfg_hit && !mem_hit)); // R4
  AST_HIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(cfg_hit && mem_hit)); // R4
  AST_MEM_GATED: assert property (@(posedge clk) disable iff (rst)
    mem_hit |-> $past(mem_en)); // R8

endmodule

// File: rtl/cfgsp_regfile.sv
module cfgsp_regfile
  import cfgsp_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID     = 16'h3C4D,
  parameter logic [7:0]  REVISION      = 8'h02,
  parameter logic [7:0]  CLASS_BASE    = 8'h01,
  parameter logic [7:0]  CLASS_SUB     = 8'h04,
  parameter logic [7:0]  CLASS_PROGIF  = 8'h00,
  parameter logic [15:0] STATUS_INIT   = 16'h0200,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter int          NUM_BARS      = 2,
  parameter int          BAR_SIZE_LOG2 = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [31:0]            wr_data,
  input  logic [3:0]             wr_be,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [31:0]            rd_word,
  output logic                   mem_en,
  output logic [NUM_BARS*32-1:0] bar_bases
);

  function automatic logic [31:0] reset_word(int idx);
    logic [31:0] v;
    v = 32'h0;
    if (idx == 0)       v = {DEVICE_ID, VENDOR_ID};
    else if (idx == 1)  v = {STATUS_INIT, 16'h0000};
    else if (idx == 2)  v = {CLASS_BASE, CLASS_SUB, CLASS_PROGIF, REVISION};
    else if (idx == 15) v = {16'h0000, INT_PIN, 8'h00};
    return v;
  endfunction

  logic [31:0] word_q [NUM_REGS];
  logic [31:0] be_mask;

  assign be_mask = be_expand(wr_be);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [31:0] WMASK = reg_wmask(i, NUM_BARS, BAR_SIZE_LOG2);
    localparam logic [31:0] RVAL  = reset_word(i);

    if (WMASK == 32'h0) begin : g_const
      assign word_q[i] = RVAL;
    end else begin : g_store
      logic [31:0] q;
      logic        hit;
      logic [31:0] m;
      assign hit = wr_en && (wr_idx == IDX_W'(i));
      assign m   = WMASK & be_mask;
      if (i == KEEP_IDX) begin : g_keep
        always_ff @(posedge clk) begin
          if (hit) q <= (q & ~m) | (wr_data & m);
        end
      end else begin : g_rst
        always_ff @(posedge clk) begin
          if (rst)      q <= RVAL;
          else if (hit) q <= (q & ~m) | (wr_data & m);
        end
      end
      assign word_q[i] = q;
    end
  end

  for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
    assign bar_bases[b*32 +: 32] = word_q[BAR_FIRST + b];
  end

  always_comb begin
    rd_word = word_q[rd_idx];
    mem_en  = word_q[CMD_IDX][MEM_EN_BIT];
  end

  initial begin
    assert (NUM_BARS >= 1 && NUM_BARS <= BAR_MAX); // R7
  end

endmodule

// File: rtl/pci_cfg_target.sv
module pci_cfg_target
  import cfgsp_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID     = 16'h3C4D,
  parameter logic [7:0]  REVISION      = 8'h02,
  parameter logic [7:0]  CLASS_BASE    = 8'h01,
  parameter logic [7:0]  CLASS_SUB     = 8'h04,
  parameter logic [7:0]  CLASS_PROGIF  = 8'h00,
  parameter logic [15:0] STATUS_INIT   = 16'h0200,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter int          NUM_BARS      = 2,
  parameter int          BAR_SIZE_LOG2 = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ap_valid,
  input  logic [31:0] ap_addr,
  input  logic [3:0]  ap_cmd,
  input  logic        ap_idsel,
  input  logic        dp_valid,
  input  logic [31:0] dp_wdata,
  input  logic [3:0]  dp_be,
  output logic        cfg_hit,
  output logic        mem_hit,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        mem_space_en
);

  logic                   pend, pend_wr, pend_inrange;
  logic [IDX_W-1:0]       pend_idx;
  logic                   wr_fire, rd_fire;
  logic [31:0]            rd_word;
  logic [NUM_BARS*32-1:0] bar_bases;

  cfgsp_decode #(
    .NUM_BARS      (NUM_BARS),
    .BAR_SIZE_LOG2 (BAR_SIZE_LOG2)
  ) u_decode (
    .clk          (clk),
    .rst          (rst),
    .ap_valid     (ap_valid),
    .ap_addr      (ap_addr),
    .ap_cmd       (ap_cmd),
    .ap_idsel     (ap_idsel),
    .dp_valid     (dp_valid),
    .mem_en       (mem_space_en),
    .bar_bases    (bar_bases),
    .cfg_hit      (cfg_hit),
    .mem_hit      (mem_hit),
    .pend         (pend),
    .pend_wr      (pend_wr),
    .pend_idx     (pend_idx),
    .pend_inrange (pend_inrange)
  );

  assign wr_fire = dp_valid && pend && pend_wr && pend_inrange;
  assign rd_fire = dp_valid && pend && !pend_wr;

  cfgsp_regfile #(
    .VENDOR_ID     (VENDOR_ID),
    .DEVICE_ID     (DEVICE_ID),
    .REVISION      (REVISION),
    .CLASS_BASE    (CLASS_BASE),
    .CLASS_SUB     (CLASS_SUB),
    .CLASS_PROGIF  (CLASS_PROGIF),
    .STATUS_INIT   (STATUS_INIT),
    .INT_PIN       (INT_PIN),
    .NUM_BARS      (NUM_BARS),
    .BAR_SIZE_LOG2 (BAR_SIZE_LOG2)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_fire),
    .wr_idx    (pend_idx),
    .wr_data   (dp_wdata),
    .wr_be     (dp_be),
    .rd_idx    (pend_idx),
    .rd_word   (rd_word),
    .mem_en    (mem_space_en),
    .bar_bases (bar_bases)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= pend_inrange ? rd_word : 32'h0;
    end
  end

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (dp_valid && pend && !pend_wr && !pend_inrange) |=> (rd_valid && rd_data == 32'h0)); // R3
  AST_RD_FOLLOWS_DP: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(dp_valid)); // R10
  AST_RESET_MEM_OFF: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_space_en && !rd_valid)); // R9
  AST_BAR_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(pend_inrange && int'(pend_idx) >= BAR_FIRST &&
                       int'(pend_idx) < BAR_FIRST + NUM_BARS))
    |-> (rd_data[BAR_SIZE_LOG2-1:0] == '0)); // R7

endmodule

// File: tb/pci_cfg_target_tb.sv
`timescale 1ns/100ps
module pci_cfg_target_tb_top;

  localparam int NB  = 2;
  localparam int LG2 = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ap_valid = 1'b0;
  logic [31:0] ap_addr = '0;
  logic [3:0]  ap_cmd = '0;
  logic        ap_idsel = 1'b0;
  logic        dp_valid = 1'b0;
  logic [31:0] dp_wdata = '0;
  logic [3:0]  dp_be = '0;
  logic        cfg_hit, mem_hit, rd_valid, mem_space_en;
  logic [31:0] rd_data;

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 0;

  logic [31:0] model [16];

  always #2.5 clk = ~clk;

  pci_cfg_target #(.NUM_BARS(NB), .BAR_SIZE_LOG2(LG2)) dut_i (
    .clk(clk), .rst(rst), .ap_valid(ap_valid), .ap_addr(ap_addr), .ap_cmd(ap_cmd),
    .ap_idsel(ap_idsel), .dp_valid(dp_valid), .dp_wdata(dp_wdata), .dp_be(dp_be),
    .cfg_hit(cfg_hit), .mem_hit(mem_hit), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_space_en(mem_space_en));

  function automatic logic [31:0] bmask(int i);
    if (i == 1)  return 32'h0000_0547;
    if (i == 3)  return 32'h0000_FFFF;
    if (i == 11) return 32'hFFFF_FFFF;
    if (i == 15) return 32'h0000_00FF;
    if (i >= 4 && i < 4 + NB) return 32'hFFFF_F000;
    return 32'h0;
  endfunction

  function automatic logic [31:0] brst(int i);
    if (i == 0)  return 32'h3C4D_1A2B;
    if (i == 1)  return 32'h0200_0000;
    if (i == 2)  return 32'h0104_0002;
    if (i == 15) return 32'h0000_0100;
    return 32'h0;
  endfunction

  function automatic logic [31:0] bexp(logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic bit claims(logic [3:0] cmd, logic [31:0] addr, logic sel);
    return sel && (cmd == 4'hA || cmd == 4'hB) && addr[1:0] == 2'b00 && addr[10:8] == 3'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_write(input int i, input logic [31:0] wd, input logic [3:0] be);
    logic [31:0] m;
    m = bmask(i) & bexp(be);
    model[i] = (model[i] & ~m) | (wd & m);
  endtask

  // Full configuration cycle: address phase, then data phase.
  task automatic cfg_cycle(input logic [3:0] cmd, input logic [31:0] addr, input logic sel,
                           input logic [31:0] wd, input logic [3:0] be,
                           output logic hit, output logic rv, output logic [31:0] rd);
    @(negedge clk);
    ap_valid = 1'b1; ap_addr = addr; ap_cmd = cmd; ap_idsel = sel;
    @(negedge clk);
    hit = cfg_hit;
    ap_valid = 1'b0; ap_idsel = 1'b0;
    dp_valid = 1'b1; dp_wdata = wd; dp_be = be;
    @(negedge clk);
    rv = rd_valid; rd = rd_data;
    dp_valid = 1'b0;
    if (claims(cmd, addr, sel) && cmd == 4'hB && addr[7:6] == 2'b00)
      model_write(int'(addr[5:2]), wd, be);
  endtask

  task automatic wr_reg(input int i, input logic [31:0] wd, input logic [3:0] be);
    logic h, v; logic [31:0] d;
    cfg_cycle(4'hB, 32'(i) << 2, 1'b1, wd, be, h, v, d);
  endtask

  task automatic rd_reg(input int i, output logic [31:0] d);
    logic h, v;
    cfg_cycle(4'hA, 32'(i) << 2, 1'b1, 32'h0, 4'h0, h, v, d);
  endtask

  task automatic mem_cycle(input logic [3:0] cmd, input logic [31:0] addr, output logic hit);
    @(negedge clk);
    ap_valid = 1'b1; ap_addr = addr; ap_cmd = cmd;
    @(negedge clk);
    hit = mem_hit;
    ap_valid = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic h, v; logic [31:0] d;
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) model[i] = brst(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 reset outputs", {cfg_hit, mem_hit, rd_valid, mem_space_en}, 4'b0000);

    wr_reg(11, 32'hCAFE_F00D, 4'hF);
    // R6 ID and class code, R10 read timing
    cfg_cycle(4'hA, 32'h0, 1'b1, 32'h0, 4'h0, h, v, d);
    chk("R10 cfg_hit after address phase", h, 1'b1);
    chk("R10 rd_valid after data phase", v, 1'b1);
    chk("R6 ID word", d, 32'h3C4D_1A2B);
    rd_reg(2, d); chk("R6 class code", d, 32'h0104_0002);
    wr_reg(0, 32'hFFFF_FFFF, 4'hF); rd_reg(0, d); chk("R6 ID ignores write", d, 32'h3C4D_1A2B);
    wr_reg(2, 32'h0, 4'hF); rd_reg(2, d); chk("R6 class ignores write", d, 32'h0104_0002);
    wr_reg(1, 32'hFFFF_FFFF, 4'hF); rd_reg(1, d); chk("R6 command mask", d, 32'h0200_0547);
    wr_reg(1, 32'h0, 4'hF);

    // R5 byte enables
    wr_reg(3, 32'h1234_5678, 4'b0001); rd_reg(3, d); chk("R5 byte0 only", d, 32'h0000_0078);
    wr_reg(3, 32'hAAAA_BBCC, 4'b0010); rd_reg(3, d); chk("R5 byte1 only", d, 32'h0000_BB78);
    wr_reg(3, 32'h1111_1111, 4'b0000); rd_reg(3, d); chk("R5 no enables", d, 32'h0000_BB78);

    // R7 BAR sizing
    wr_reg(4, 32'hFFFF_FFFF, 4'hF); rd_reg(4, d); chk("R7 BAR0 sizing", d, 32'hFFFF_F000);
    wr_reg(9, 32'hFFFF_FFFF, 4'hF); rd_reg(9, d); chk("R7 absent BAR zero", d, 32'h0);

    // R1 Type 1 ignored
    cfg_cycle(4'hA, 32'h0000_0001, 1'b1, 32'h0, 4'h0, h, v, d);
    chk("R1 type1 read no hit", {h, v}, 2'b00);
    cfg_cycle(4'hB, 32'h0000_000D, 1'b1, 32'hFFFF_FFFF, 4'hF, h, v, d);
    chk("R1 type1 write no hit", h, 1'b0);
    rd_reg(3, d); chk("R1 type1 write no effect", d, model[3]);

    // R2 function number and select
    cfg_cycle(4'hA, 32'h0000_0100, 1'b1, 32'h0, 4'h0, h, v, d);
    chk("R2 function 1 not claimed", {h, v}, 2'b00);
    cfg_cycle(4'hB, 32'h0000_0000 | (32'd3 << 2), 1'b0, 32'hFFFF, 4'hF, h, v, d);
    chk("R2 idsel low not claimed", h, 1'b0);
    rd_reg(3, d); chk("R2 unclaimed write no effect", d, model[3]);

    // R3 out of range
    cfg_cycle(4'hA, 32'd16 << 2, 1'b1, 32'h0, 4'h0, h, v, d);
    chk("R3 reg16 claimed", {h, v}, 2'b11);
    chk("R3 reg16 reads zero", d, 32'h0);
    cfg_cycle(4'hA, 32'd63 << 2, 1'b1, 32'h0, 4'h0, h, v, d);
    chk("R3 reg63 reads zero", d, 32'h0);
    wr_reg(4, 32'h8000_0000, 4'hF);
    wr_reg(20, 32'h1234_5000, 4'hF); rd_reg(4, d); chk("R3 write reg20 ignored", d, 32'h8000_0000);

    // R8 memory enable gating, R4 commands
    mem_cycle(4'h6, 32'h8000_0010, h); chk("R8 mem disabled no hit", h, 1'b0);
    chk("R8 enable low", mem_space_en, 1'b0);
    wr_reg(1, 32'h0000_0002, 4'h1);
    chk("R8 enable high", mem_space_en, 1'b1);
    mem_cycle(4'h6, 32'h8000_0010, h); chk("R8 mem read hit", h, 1'b1);
    mem_cycle(4'h7, 32'h8000_0FFC, h); chk("R4 mem write hit", h, 1'b1);
    mem_cycle(4'h6, 32'h8000_1000, h); chk("R8 outside window", h, 1'b0);
    mem_cycle(4'h2, 32'h8000_0010, h); chk("R4 io read ignored", h, 1'b0);
    mem_cycle(4'hC, 32'h8000_0010, h); chk("R4 read multiple ignored", h, 1'b0);
    cfg_cycle(4'h4, 32'h0, 1'b1, 32'h0, 4'h0, h, v, d);
    chk("R4 other cmd no cfg hit", {h, v, mem_hit}, 3'b000);

    // R11 overlap: clearing write data phase with memory address phase
    @(negedge clk);
    ap_valid = 1'b1; ap_addr = 32'h4; ap_cmd = 4'hB; ap_idsel = 1'b1;
    @(negedge clk);
    chk("R11 cmd write claimed", cfg_hit, 1'b1);
    ap_idsel = 1'b0; ap_addr = 32'h8000_0020; ap_cmd = 4'h6;
    dp_valid = 1'b1; dp_wdata = 32'h0; dp_be = 4'h3;
    @(negedge clk);
    dp_valid = 1'b0;
    chk("R11 overlap uses old enable", mem_hit, 1'b1);
    @(negedge clk);
    ap_valid = 1'b0;
    chk("R11 next cycle disabled", mem_hit, 1'b0);
    model_write(1, 32'h0, 4'h3);
    rd_reg(1, d); chk("R11 command after overlap", d, model[1]);

    // R9 reset preservation
    wr_reg(1, 32'h0000_0106, 4'hF);
    wr_reg(15, 32'h0000_002A, 4'hF);
    rd_reg(15, d); chk("R6 int line writable", d, 32'h0000_012A);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 16; i++) if (i != 11) model[i] = brst(i);
    chk("R9 enable cleared", mem_space_en, 1'b0);
    rd_reg(11, d); chk("R9 reg11 preserved", d, 32'hCAFE_F00D);
    rd_reg(15, d); chk("R9 int line default", d, 32'h0000_0100);
    rd_reg(1, d);  chk("R9 command default", d, 32'h0200_0000);
    rd_reg(4, d);  chk("R9 BAR default", d, 32'h0);

    // Random mix, R5 R6 R10 R1 R2 R3
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a, wd; logic [3:0] cmd, be; logic sel; int rn; bit exp_claim;
      rn  = int'($urandom % 20);
      a   = 32'(rn) << 2;
      if ($urandom % 8 == 0) a[1:0] = 2'b01;
      if ($urandom % 8 == 0) a[10:8] = 3'(($urandom % 7) + 1);
      sel = ($urandom % 10 != 0);
      cmd = ($urandom % 2 == 0) ? 4'hA : 4'hB;
      wd  = $urandom;
      be  = 4'($urandom);
      exp_claim = claims(cmd, a, sel);
      cfg_cycle(cmd, a, sel, wd, be, h, v, d);
      chk("R10 random claim", h, 1'(exp_claim));
      if (exp_claim && cmd == 4'hA)
        chk("R5 random read", d, (rn < 16) ? model[rn] : 32'h0);
      else
        chk("R1 random no read", v, 1'b0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule